// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block is the digital core of a synchronous buck half-bridge driver. It takes one PWM level and produces two gate-enable outputs, `hs_en` for the upper switch and `ls_en` for the lower switch. The outputs never overlap. `hs_en` runs in phase with the PWM input and `ls_en` in antiphase. An active-high `gate_allow` input can force both outputs off at any moment, including in the middle of a handover.

The handover from high side to low side is adaptive. After `hs_en` drops, the controller watches a digitised flag from the switch node that reads high while the node sits above about 1 V. The low side turns on once that flag has been seen high and has then fallen. If the flag is never seen high, the low side turns on after a fixed wait. If the node stays high, a hard timeout turns the low side on anyway, which covers negative inductor current.

The handover from low side to high side works differently. After `ls_en` drops, the controller waits for a flag saying the lower gate has fallen below one sixth of the supply, then waits a short fixed delay before raising `hs_en`. All four inputs pass through two-stage synchronisers. Both outputs are registered. Every delay is a parameter counted in clock cycles. The defaults, at a 5 ns clock, are 150 ns (`FIXED_DLY` = 30), 190 ns (`TIMEOUT` = 38) and 20 ns (`HS_DLY` = 4). A full sequence therefore fits well inside the 1 us half-period of a 500 kHz PWM. The block has no data stream, so all of its pins are plain control levels.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: With `gate_allow` high and no handover pending, `hs_en` equals the PWM level and `ls_en` is its inverse.
- R2: `hs_en` and `ls_en` are never high in the same cycle.
- R3: When `gate_allow` goes low, both outputs are low from the third rising clock edge after the change. They stay low for as long as it is held low, in any state. A turn-on that was pending is discarded rather than carried out later.
- R4: A PWM falling edge drops `hs_en` on the third rising edge after it. `ls_en` stays low while the handover waits. If `sw_above` has been seen high during the wait, `ls_en` rises on the third rising edge after `sw_above` falls, provided the timeout has not come first.
- R5: If `sw_above` is never seen high after `hs_en` drops, `ls_en` rises exactly `FIXED_DLY` clock edges after the edge that dropped `hs_en`.
- R6: If `sw_above` stays high, `ls_en` rises exactly `TIMEOUT` clock edges after the edge that dropped `hs_en`.
- R7: A PWM rising edge drops `ls_en` on the third rising edge after it. While the controller is waiting for the lower gate, `hs_en` rises on the (3 + `HS_DLY`)th rising edge after `lsg_below` rises.
- R8: If the PWM level reverses before a pending turn-on completes, that turn-on is abandoned. The opposite sequence starts from the all-off state, and no output pulses on the way.
- R9: After reset, and while `gate_allow` is low, both outputs are low. When `gate_allow` rises, the sampled PWM level selects a normal handover path. With PWM low and no switch-node activity, `ls_en` rises on edge 3 + `FIXED_DLY`. With PWM high and the lower gate already low, `hs_en` rises on edge 4 + `HS_DLY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM level; high requests the upper switch |
| gate_allow | input | 1 | Low forces both gate enables off |
| sw_above | input | 1 | Switch node above about 1 V (digitised comparator) |
| lsg_below | input | 1 | Lower gate below one sixth of supply (digitised comparator) |
| hs_en | output | 1 | Upper switch gate enable |
| ls_en | output | 1 | Lower switch gate enable |

## Verification
The interactions that matter are those where a pending turn-on meets a competing event in the same handover window. One case is a PWM reversal arriving while the fixed-delay count toward `ls_en` is still running. Another is `gate_allow` falling while the timeout would otherwise fire a few cycles later. The bench provokes both: it reverses the PWM a few cycles after `hs_en` drops, and it removes `gate_allow` inside a stuck-high switch-node wait. A behavioural reference model, compared every cycle, judges each case, together with directed counts that confirm the abandoned output never rises.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_ON   = 3'd1,
    ST_HL_WAIT = 3'd2,
    ST_LS_ON   = 3'd3,
    ST_LH_WAIT = 3'd4,
    ST_LH_DLY  = 3'd5
  } dtc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/dtc_sync.sv
`timescale 1ns/1ps
module dtc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dtc_timer.sv
`timescale 1ns/1ps
module dtc_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/dtc_fsm.sv
`timescale 1ns/1ps
module dtc_fsm
  import dtc_pkg::*;
#(
  parameter int FIXED_DLY = 30,
  parameter int TIMEOUT   = 38,
  parameter int HS_DLY    = 4,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_pwm,
  input  logic          s_allow,
  input  logic          s_sw,
  input  logic          s_lsl,
  input  logic [CW-1:0] cnt,
  output logic          clr,
  output logic          hs_q,
  output logic          ls_q
);

  localparam logic [CW-1:0] FIX_LAST = CW'(FIXED_DLY - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] HSD_LAST = CW'(HS_DLY - 1);

  dtc_state_e st, nxt;
  logic       seen_q;
  logic       fall_hit, fixed_hit, tmo_hit;

  assign fall_hit  = seen_q && !s_sw;
  assign fixed_hit = (cnt == FIX_LAST) && !seen_q && !s_sw;
  assign tmo_hit   = (cnt == TMO_LAST);

  always_comb begin
    nxt = st;
    if (!s_allow) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:    nxt = s_pwm ? ST_LH_WAIT : ST_HL_WAIT;
        ST_HS_ON:   if (!s_pwm) nxt = ST_HL_WAIT;
        ST_HL_WAIT: begin
          if (s_pwm)                               nxt = ST_LH_WAIT;
          else if (tmo_hit || fall_hit || fixed_hit) nxt = ST_LS_ON;
        end
        ST_LS_ON:   if (s_pwm) nxt = ST_LH_WAIT;
        ST_LH_WAIT: begin
          if (!s_pwm)     nxt = ST_HL_WAIT;
          else if (s_lsl) nxt = ST_LH_DLY;
        end
        ST_LH_DLY: begin
          if (!s_pwm)               nxt = ST_HL_WAIT;
          else if (cnt == HSD_LAST) nxt = ST_HS_ON;
        end
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  assign clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      seen_q <= 1'b0;
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      st <= nxt;
      if (st != ST_HL_WAIT || nxt != ST_HL_WAIT) seen_q <= 1'b0;
      else if (s_sw)                             seen_q <= 1'b1;
      hs_q <= (nxt == ST_HS_ON);
      ls_q <= (nxt == ST_LS_ON);
    end
  end

  // R2
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  // R3
  a_r3_disable_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !s_allow |=> (!hs_q && !ls_q));

  // R4
  a_r4_ls_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));

  // R6
  a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HL_WAIT) |-> (cnt < CW'(TIMEOUT)));

  // R7
  a_r7_hs_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !$past(ls_q));

endmodule

// File: rtl/deadtime_gate_ctrl.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl
  import dtc_pkg::*;
#(
  parameter int FIXED_DLY   = 30,
  parameter int TIMEOUT     = 38,
  parameter int HS_DLY      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic gate_allow,
  input  logic sw_above,
  input  logic lsg_below,
  output logic hs_en,
  output logic ls_en
);

  localparam int CMAX = max3(FIXED_DLY, TIMEOUT, HS_DLY);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int NIN  = 4;

  logic [NIN-1:0] raw_in, syn_in;
  logic [CW-1:0]  cnt;
  logic           clr;

  assign raw_in = {pwm_in, gate_allow, sw_above, lsg_below};

  dtc_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn_in)
  );

  dtc_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .cnt  (cnt)
  );

  dtc_fsm #(
    .FIXED_DLY(FIXED_DLY),
    .TIMEOUT  (TIMEOUT),
    .HS_DLY   (HS_DLY),
    .CW       (CW)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_pwm  (syn_in[3]),
    .s_allow(syn_in[2]),
    .s_sw   (syn_in[1]),
    .s_lsl  (syn_in[0]),
    .cnt    (cnt),
    .clr    (clr),
    .hs_q   (hs_en),
    .ls_q   (ls_en)
  );

endmodule

// File: tb/deadtime_gate_ctrl_bench.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl_bench;

  localparam int FIX = 30;
  localparam int TMO = 38;
  localparam int HSD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, allow = 1'b0, sw = 1'b0;
  logic [2:0] lpipe;
  logic lsl;
  logic hs, ls;

  int ncmp = 0, nfail = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  deadtime_gate_ctrl #(.FIXED_DLY(FIX), .TIMEOUT(TMO), .HS_DLY(HSD)) u_deadtime_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .gate_allow(allow),
    .sw_above(sw), .lsg_below(lsl), .hs_en(hs), .ls_en(ls)
  );

  // lower-gate comparator emulation: follows !ls_en with a lag
  always @(negedge clk) begin
    if (!rst_n) lpipe <= 3'b000;
    else        lpipe <= {lpipe[1:0], !ls};
  end
  assign lsl = lpipe[2];

  // behavioural reference model
  bit hp [2], ha [2], hw [2], hl [2];
  int ph = 0, el = 0;
  bit seen = 0, ehs = 0, els = 0;

  always @(posedge clk) begin
    bit up, ua, us, ul;
    int nph;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin hp[i] = 0; ha[i] = 0; hw[i] = 0; hl[i] = 0; end
      ph = 0; el = 0; seen = 0; ehs = 0; els = 0;
    end else begin
      up = hp[1]; ua = ha[1]; us = hw[1]; ul = hl[1];
      hp[1] = hp[0]; ha[1] = ha[0]; hw[1] = hw[0]; hl[1] = hl[0];
      hp[0] = pwm; ha[0] = allow; hw[0] = sw; hl[0] = lsl;
      nph = ph;
      if (!ua) nph = 0;
      else case (ph)
        0: nph = up ? 4 : 2;
        1: if (!up) nph = 2;
        2: if (up) nph = 4;
           else if (el == TMO-1) nph = 3;
           else if (seen && !us) nph = 3;
           else if (el == FIX-1 && !seen && !us) nph = 3;
        3: if (up) nph = 4;
        4: if (!up) nph = 2; else if (ul) nph = 5;
        5: if (!up) nph = 2; else if (el == HSD-1) nph = 1;
        default: nph = 0;
      endcase
      if (ph == 2 && nph == 2) seen = seen | us; else seen = 0;
      if (nph != ph) el = 0; else el++;
      ph = nph;
      ehs = (ph == 1);
      els = (ph == 3);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      ncmp++;
      if (hs !== ehs || ls !== els) begin
        nfail++;
        $display("FAIL %s per-cycle: hs=%b ls=%b expected hs=%b ls=%b", cur_req, hs, ls, ehs, els);
      end
      ncmp++;
      if (hs && ls) begin
        nfail++;
        $display("FAIL R2 overlap: hs=%b ls=%b expected not both high", hs, ls);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) begin @(negedge clk); #1; end
  endtask

  function automatic bit sig(input int w);
    case (w)
      0: return hs;
      1: return ls;
      default: return lsl;
    endcase
  endfunction

  task automatic wait_for(input int w, input bit v, input int lim, output int n);
    n = 0;
    do begin step(1); n++; end while (sig(w) !== v && n < lim);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
  endtask

  initial begin
    int n;
    bit bad;
    step(4);
    chk(hs == 0 && ls == 0, "R9", "outputs in reset", {hs, ls}, 0);
    rst_n = 1'b1;
    step(6);
    chk(hs == 0 && ls == 0, "R9", "outputs held off while disallowed", {hs, ls}, 0);

    // R9 re-enable with PWM low, fixed path
    cur_req = "R9";
    allow = 1'b1;
    wait_for(1, 1, 100, n);
    chk(n == 3 + FIX, "R9", "ls rise after enable", n, 3 + FIX);
    step(4);
    chk(hs == 0 && ls == 1, "R1", "steady low PWM", {hs, ls}, 1);

    // R7 low-to-high handover
    cur_req = "R7";
    pwm = 1'b1;
    wait_for(1, 0, 50, n);
    chk(n == 3, "R7", "ls drop latency", n, 3);
    wait_for(2, 1, 50, n);
    wait_for(0, 1, 50, n);
    chk(n == 3 + HSD, "R7", "hs rise after lower gate flag", n, 3 + HSD);
    step(4);
    chk(hs == 1 && ls == 0, "R1", "steady high PWM", {hs, ls}, 2);

    // R4 adaptive fall
    cur_req = "R4";
    sw = 1'b1;
    step(4);
    pwm = 1'b0;
    wait_for(0, 0, 50, n);
    chk(n == 3, "R4", "hs drop latency", n, 3);
    step(6);
    chk(ls == 0, "R4", "ls waits while node high", ls, 0);
    sw = 1'b0;
    wait_for(1, 1, 50, n);
    chk(n == 3, "R4", "ls rise after node fall", n, 3);

    // R5 no rise seen
    cur_req = "R5";
    pwm = 1'b1;
    wait_for(0, 1, 60, n);
    step(4);
    pwm = 1'b0;
    wait_for(0, 0, 50, n);
    wait_for(1, 1, 100, n);
    chk(n == FIX, "R5", "fixed delay length", n, FIX);

    // R6 stuck-high switch node
    cur_req = "R6";
    pwm = 1'b1;
    wait_for(0, 1, 60, n);
    sw = 1'b1;
    step(4);
    pwm = 1'b0;
    wait_for(0, 0, 50, n);
    wait_for(1, 1, 100, n);
    chk(n == TMO, "R6", "timeout length", n, TMO);
    sw = 1'b0;
    step(4);

    // R8 reversal during high-to-low wait
    cur_req = "R8";
    pwm = 1'b1;
    wait_for(0, 1, 60, n);
    step(4);
    pwm = 1'b0;
    wait_for(0, 0, 50, n);
    step(5);
    pwm = 1'b1;
    bad = 0;
    n = 0;
    do begin step(1); n++; if (ls) bad = 1; end while (!hs && n < 80);
    chk(!bad, "R8", "ls pulse during abandoned turn-on", bad, 0);
    chk(hs == 1, "R8", "hs restored after reversal", hs, 1);

    // R8 reversal during low-to-high wait
    pwm = 1'b0;
    wait_for(1, 1, 100, n);
    step(4);
    pwm = 1'b1;
    wait_for(1, 0, 50, n);
    pwm = 1'b0;
    bad = 0;
    n = 0;
    do begin step(1); n++; if (hs) bad = 1; end while (!ls && n < 100);
    chk(!bad, "R8", "hs pulse during abandoned turn-on", bad, 0);
    chk(ls == 1, "R8", "ls restored after reversal", ls, 1);

    // R3 disable inside a stuck-high wait
    cur_req = "R3";
    pwm = 1'b1;
    wait_for(0, 1, 60, n);
    sw = 1'b1;
    step(3);
    pwm = 1'b0;
    wait_for(0, 0, 50, n);
    step(3);
    allow = 1'b0;
    bad = 0;
    for (int i = 0; i < TMO + 10; i++) begin step(1); if (ls || hs) bad = 1; end
    chk(!bad, "R3", "pending timeout discarded", bad, 0);
    sw = 1'b0;
    pwm = 1'b1;
    step(4);

    // R9 re-enable with PWM high
    cur_req = "R9";
    allow = 1'b1;
    wait_for(0, 1, 50, n);
    chk(n == 4 + HSD, "R9", "hs rise after enable", n, 4 + HSD);
    step(5);

    // R3 disable while high side on
    cur_req = "R3";
    allow = 1'b0;
    wait_for(0, 0, 20, n);
    chk(n == 3, "R3", "hs off after disable", n, 3);
    step(10);
    chk(hs == 0 && ls == 0, "R3", "held off", {hs, ls}, 0);

    // R3 disable while low side on
    pwm = 1'b0;
    allow = 1'b1;
    wait_for(1, 1, 100, n);
    step(3);
    allow = 1'b0;
    wait_for(1, 0, 20, n);
    chk(n == 3, "R3", "ls off after disable", n, 3);
    step(5);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ncmp++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule